// File: doc/BRIEF.md
# Synthesizer Configuration SPI Slave

This block lets a host microcontroller program a frequency synthesizer over a four-wire serial link. Four 8-bit configuration registers hold the synthesizer's settings: a 10-bit feedback divider, a 6-bit reference divider, and a control register. The control register has a squelch-inhibit flag, a calibration-mode flag and a 2-bit output-current code. The serial pins are sampled with the system clock through synchronizers, so the serial clock may stop whenever chip select is high.

A frame opens when chip select falls. It carries byte pairs, each an address byte followed by a value byte, sent most significant bit first. A write does not change the live configuration straight away. Its value is held in a shadow copy, and every shadow value written in the frame moves into the live registers together when chip select rises. A one-cycle strobe per written register tells downstream control logic, such as a calibration sequencer, which settings changed. A read returns the live value on the serial output during the value byte.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset every live register is 0x00, so all configuration fields are zero, no strobe is raised, and the serial output enable is low.
- R2: A byte pair is an address byte then a value byte, each sent MSB first and sampled on the rising serial clock edge. Address bit 7 set means read and clear means write. Address bits 1:0 pick the register. Address bits 6:2 must be zero.
- R3: A written value does not reach the live fields while chip select stays low. It takes effect only after chip select rises.
- R4: Several byte pairs may follow one another in one frame. Bytes keep alternating between address and value, and every write in the frame takes effect at the same commit.
- R5: At commit, the strobe bit of each register written in the frame (bit i for register i) is high for exactly one cycle. All such bits rise in the same cycle, and registers not written get no strobe.
- R6: A read returns the live value, not a value staged earlier in the same frame. Its bit 7 is launched on the falling serial clock edge that ends the address byte, and the next bits follow on the next falling edges.
- R7: Unused register bits are stored and read back as 0. The usable bits are: register 0 bits 7:0, register 1 bits 1:0, register 2 bits 5:0, register 3 bits 3:0.
- R8: A write to an address whose bits 6:2 are not all zero changes nothing and gives no strobe. A read of such an address returns 0x00.
- R9: The serial output is driven low during address bytes and write value bytes. Its enable is low whenever chip select is high or the sleep input is low.
- R10: The feedback divider is {reg1[1:0], reg0}. The reference divider is reg2[5:0]. From reg3, bit 3 is squelch inhibit, bit 2 is calibration mode, and bits 1:0 are the output-current code.
- R11: If one register is written twice in a frame, the later value is committed, and it gets a single strobe.
- R12: A byte that is cut short by chip select rising is discarded. Complete writes earlier in the same frame are still committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n | input | 1 | Low puts the serial output in high impedance |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing an access |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (valid when enable high) |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| ndiv | output | 10 | Live feedback divider value |
| rdiv | output | 6 | Live reference divider value |
| squelch_inh | output | 1 | Live squelch-inhibit flag |
| cal_mode | output | 1 | Live calibration-mode flag |
| out_cur | output | 2 | Live output-current code |
| reg_wr_stb | output | 4 | One-cycle per-register commit strobe |

## Verification
The bench looks at the live fields just before chip select rises. A design that commits on the value byte would already show the new divider there. It reads back a register after staging a new value in the same frame, which catches a design that returns the shadow copy. Reserved addresses, a register written twice, and a frame cut off in the middle of a byte each show up as wrong live values or extra or missing strobes. The bench also samples the serial output during write bytes and while the sleep input is low, to catch a driven or nonzero line where it must be quiet.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

   localparam int REG_W    = 8;
   localparam int NUM_REGS = 4;
   localparam int IDX_W    = $clog2(NUM_REGS);

   // Writable bits of each register, register 0 in the lowest byte
   localparam logic [NUM_REGS*REG_W-1:0] REG_MASK = {8'h0F, 8'h3F, 8'h03, 8'hFF};

   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } byte_phase_e;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d_in};
      end
   end

   assign d_out = stg[STAGES-1];

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
   import cfg_spi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             cs_n_s,
   input  logic             mosi_s,
   output logic             sck_fall,
   output logic             cs_rise,
   output logic             rd_start,
   output logic             rd_hit,
   output logic [IDX_W-1:0] rd_idx,
   output logic             rd_active,
   output logic             wr_stage,
   output logic [IDX_W-1:0] wr_idx,
   output logic [REG_W-1:0] wr_data
);

   localparam int CNT_W = $clog2(REG_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);

   logic             sck_q, cs_q;
   logic             sck_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [REG_W-1:0] sh;
   logic [REG_W-1:0] addr_q;
   logic [REG_W-1:0] next_byte;
   logic             byte_done;
   byte_phase_e      phase;

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign cs_rise   = cs_n_s & ~cs_q;
   assign next_byte = {sh[REG_W-2:0], mosi_s};
   assign byte_done = sck_rise & ~cs_n_s & (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         bit_cnt <= '0;
         sh      <= '0;
         addr_q  <= '0;
         phase   <= PH_ADDR;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
         if (cs_n_s) begin
            bit_cnt <= '0;
            phase   <= PH_ADDR;
         end else if (sck_rise) begin
            sh      <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
               if (phase == PH_ADDR) begin
                  addr_q <= next_byte;
                  phase  <= PH_DATA;
               end else begin
                  phase  <= PH_ADDR;
               end
            end
         end
      end
   end

   // Address decode: bit 7 is direction, reserved bits must be zero
   assign rd_start  = byte_done & (phase == PH_ADDR) & next_byte[REG_W-1];
   assign rd_hit    = (next_byte[REG_W-2:IDX_W] == '0);
   assign rd_idx    = next_byte[IDX_W-1:0];
   assign rd_active = (phase == PH_DATA) & addr_q[REG_W-1] & ~cs_n_s;

   assign wr_stage  = byte_done & (phase == PH_DATA) & ~addr_q[REG_W-1]
                      & (addr_q[REG_W-2:IDX_W] == '0);
   assign wr_idx    = addr_q[IDX_W-1:0];
   assign wr_data   = next_byte;

endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
   import cfg_spi_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      stage_en,
   input  logic [IDX_W-1:0]          stage_idx,
   input  logic [REG_W-1:0]          stage_data,
   input  logic                      commit,
   output logic [NUM_REGS*REG_W-1:0] live_flat,
   output logic [NUM_REGS-1:0]       commit_stb
);

   generate
      for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         localparam logic [REG_W-1:0] MASK = REG_MASK[gi*REG_W +: REG_W];
         logic [REG_W-1:0] shadow_q;
         logic [REG_W-1:0] live_q;
         logic             pend_q;
         logic             stb_q;
         logic             hit;

         assign hit = stage_en & (stage_idx == IDX_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               live_q   <= '0;
               pend_q   <= 1'b0;
               stb_q    <= 1'b0;
            end else begin
               stb_q <= commit & pend_q;
               if (commit) begin
                  if (pend_q) live_q <= shadow_q;
                  pend_q <= 1'b0;
               end else if (hit) begin
                  shadow_q <= stage_data & MASK;
                  pend_q   <= 1'b1;
               end
            end
         end

         assign live_flat[gi*REG_W +: REG_W] = live_q;
         assign commit_stb[gi]               = stb_q;
      end
   endgenerate

endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx
   import cfg_spi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             load,
   input  logic [REG_W-1:0] load_val,
   input  logic             shift_en,
   input  logic             active,
   output logic             miso_bit
);

   logic [REG_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh    <= '0;
         miso_bit <= 1'b0;
      end else if (idle) begin
         tx_sh    <= '0;
         miso_bit <= 1'b0;
      end else if (load) begin
         tx_sh <= load_val;
      end else if (shift_en) begin
         miso_bit <= active ? tx_sh[REG_W-1] : 1'b0;
         if (active) tx_sh <= {tx_sh[REG_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
   import cfg_spi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_n,
   input  logic                spi_sck,
   input  logic                spi_cs_n,
   input  logic                spi_mosi,
   output logic                spi_miso,
   output logic                spi_miso_oe,
   output logic [9:0]          ndiv,
   output logic [5:0]          rdiv,
   output logic                squelch_inh,
   output logic                cal_mode,
   output logic [1:0]          out_cur,
   output logic [NUM_REGS-1:0] reg_wr_stb
);

   generate
      if (NUM_REGS != 4 || REG_W != 8) begin : g_bad_map
         $error("cfg_spi_slave: field map expects four 8-bit registers");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       sck_s, cs_n_s, mosi_s;

   cfg_spi_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_mosi, spi_cs_n, spi_sck}),
      .d_out (pins_s)
   );

   assign {mosi_s, cs_n_s, sck_s} = pins_s;

   logic             sck_fall, cs_rise, rd_start, rd_hit, rd_active, wr_stage;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [REG_W-1:0] wr_data, rd_data;
   logic [NUM_REGS*REG_W-1:0] live_flat;

   cfg_spi_frame frame_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_n_s    (cs_n_s),
      .mosi_s    (mosi_s),
      .sck_fall  (sck_fall),
      .cs_rise   (cs_rise),
      .rd_start  (rd_start),
      .rd_hit    (rd_hit),
      .rd_idx    (rd_idx),
      .rd_active (rd_active),
      .wr_stage  (wr_stage),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data)
   );

   cfg_spi_regs regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_en   (wr_stage),
      .stage_idx  (wr_idx),
      .stage_data (wr_data),
      .commit     (cs_rise),
      .live_flat  (live_flat),
      .commit_stb (reg_wr_stb)
   );

   assign rd_data = rd_hit ? live_flat[rd_idx*REG_W +: REG_W] : '0;

   cfg_spi_tx tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (cs_n_s),
      .load     (rd_start),
      .load_val (rd_data),
      .shift_en (sck_fall),
      .active   (rd_active),
      .miso_bit (spi_miso)
   );

   assign spi_miso_oe = ~cs_n_s & sleep_n;

   assign ndiv        = {live_flat[REG_W +: 2], live_flat[0 +: REG_W]};
   assign rdiv        = live_flat[2*REG_W +: 6];
   assign squelch_inh = live_flat[3*REG_W + 3];
   assign cal_mode    = live_flat[3*REG_W + 2];
   assign out_cur     = live_flat[3*REG_W +: 2];

endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_n,
   input logic       spi_miso_oe,
   input logic [9:0] ndiv,
   input logic [5:0] rdiv,
   input logic       squelch_inh,
   input logic       cal_mode,
   input logic [1:0] out_cur,
   input logic [3:0] reg_wr_stb
);

   logic [19:0] fields;
   assign fields = {ndiv, rdiv, squelch_inh, cal_mode, out_cur};

   assert_stb_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb != 4'b0) |=> (reg_wr_stb == 4'b0));

   assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb == 4'b0) |-> $stable(fields));

   assert_commit_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb != 4'b0) |-> !spi_miso_oe);

   assert_sleep_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |-> !spi_miso_oe);

endmodule

bind cfg_spi_slave cfg_spi_slave_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_n     (sleep_n),
   .spi_miso_oe (spi_miso_oe),
   .ndiv        (ndiv),
   .rdiv        (rdiv),
   .squelch_inh (squelch_inh),
   .cal_mode    (cal_mode),
   .out_cur     (out_cur),
   .reg_wr_stb  (reg_wr_stb)
);

// File: tb/cfg_spi_slave_tb_top.sv
module cfg_spi_slave_tb_top;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_n = 1'b1;
   logic       spi_sck = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       spi_miso, spi_miso_oe;
   logic [9:0] ndiv;
   logic [5:0] rdiv;
   logic       squelch_inh, cal_mode;
   logic [1:0] out_cur;
   logic [3:0] reg_wr_stb;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] exp_r [4];
   logic [3:0] stb_acc = '0;
   int         stb_cycles = 0;
   logic       stb_clr = 1'b0;

   always #2 clk = ~clk;

   cfg_spi_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .ndiv(ndiv), .rdiv(rdiv), .squelch_inh(squelch_inh),
      .cal_mode(cal_mode), .out_cur(out_cur), .reg_wr_stb(reg_wr_stb)
   );

   always @(posedge clk) begin
      if (stb_clr) begin
         stb_acc    <= '0;
         stb_cycles <= 0;
      end else if (rst_n && reg_wr_stb != 4'b0) begin
         stb_acc    <= stb_acc | reg_wr_stb;
         stb_cycles <= stb_cycles + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_stb();
      @(negedge clk) stb_clr = 1'b1;
      @(negedge clk) stb_clr = 1'b0;
   endtask

   task automatic check_fields(input string req);
      check(req, {22'b0, ndiv}, {22'b0, exp_r[1][1:0], exp_r[0]});
      check(req, {26'b0, rdiv}, {26'b0, exp_r[2][5:0]});
      check(req, {28'b0, squelch_inh, cal_mode, out_cur}, {28'b0, exp_r[3][3:0]});
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         spi_mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      spi_bits(tx, 8, rx);
   endtask

   task automatic cs_open();
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_close();
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 ndiv", {22'b0, ndiv}, 32'h0);
      check("R1 rdiv", {26'b0, rdiv}, 32'h0);
      check("R1 ctrl", {28'b0, squelch_inh, cal_mode, out_cur}, 32'h0);
      check("R1 strobes", stb_cycles, 0);
      check("R1 oe", spi_miso_oe, 1'b0);
   endtask

   task automatic t_single_write();
      logic [7:0] rx;
      clear_stb();
      cs_open();
      spi_byte(8'h02, rx);
      spi_byte(8'h25, rx);
      check("R3 no effect before cs rise", {26'b0, rdiv}, 32'h0);
      cs_close();
      exp_r[2] = 8'h25;
      check_fields("R10 single write");
      check("R5 strobe bits", stb_acc, 4'b0100);
      check("R5 strobe cycles", stb_cycles, 1);
   endtask

   task automatic t_multi_write();
      logic [7:0] rx;
      logic [7:0] wrx;
      wrx = '0;
      clear_stb();
      cs_open();
      spi_byte(8'h01, rx); wrx |= rx;
      spi_byte(8'hFE, rx); wrx |= rx;
      spi_byte(8'h00, rx); wrx |= rx;
      spi_byte(8'h5A, rx); wrx |= rx;
      spi_byte(8'h03, rx); wrx |= rx;
      check("R9 oe during frame", spi_miso_oe, 1'b1);
      spi_byte(8'hFF, rx); wrx |= rx;
      check("R9 miso low during write", {24'b0, wrx}, 32'h0);
      check("R3 multi not yet live", {22'b0, ndiv}, 32'h0);
      cs_close();
      exp_r[1] = 8'h02; exp_r[0] = 8'h5A; exp_r[3] = 8'h0F;
      check_fields("R4 R7 R10 multi write");
      check("R5 multi strobe bits", stb_acc, 4'b1011);
      check("R5 multi strobe same cycle", stb_cycles, 1);
   endtask

   task automatic t_read_all();
      logic [7:0] rx;
      cs_open();
      for (int r = 0; r < 4; r++) begin
         spi_byte(8'h80 | 8'(r), rx);
         check("R2 addr byte miso low", {24'b0, rx}, 32'h0);
         spi_byte(8'h00, rx);
         check("R6 R7 readback", {24'b0, rx}, {24'b0, exp_r[r]});
      end
      cs_close();
   endtask

   task automatic t_read_live();
      logic [7:0] rx;
      clear_stb();
      cs_open();
      spi_byte(8'h02, rx);
      spi_byte(8'h11, rx);
      spi_byte(8'h82, rx);
      spi_byte(8'h00, rx);
      check("R6 read returns live value", {24'b0, rx}, {24'b0, exp_r[2]});
      cs_close();
      exp_r[2] = 8'h11;
      check_fields("R3 commit after read");
   endtask

   task automatic t_out_of_range();
      logic [7:0] rx;
      clear_stb();
      cs_open();
      spi_byte(8'h05, rx);
      spi_byte(8'hAA, rx);
      spi_byte(8'h44, rx);
      spi_byte(8'h33, rx);
      spi_byte(8'h86, rx);
      spi_byte(8'h00, rx);
      check("R8 read out of range", {24'b0, rx}, 32'h0);
      cs_close();
      check_fields("R8 write ignored");
      check("R8 no strobe", stb_cycles, 0);
   endtask

   task automatic t_last_wins();
      logic [7:0] rx;
      clear_stb();
      cs_open();
      spi_byte(8'h00, rx);
      spi_byte(8'h11, rx);
      spi_byte(8'h00, rx);
      spi_byte(8'h22, rx);
      cs_close();
      exp_r[0] = 8'h22;
      check_fields("R11 last write wins");
      check("R11 single strobe", stb_cycles, 1);
      check("R11 strobe bit", stb_acc, 4'b0001);
   endtask

   task automatic t_truncated();
      logic [7:0] rx;
      clear_stb();
      cs_open();
      spi_byte(8'h02, rx);
      spi_byte(8'h2C, rx);
      spi_byte(8'h00, rx);
      spi_bits(8'h99, 5, rx);
      cs_close();
      exp_r[2] = 8'h2C;
      check_fields("R12 truncated byte dropped");
      check("R12 strobe bits", stb_acc, 4'b0100);
   endtask

   task automatic t_sleep();
      cs_open();
      check("R9 oe with cs low", spi_miso_oe, 1'b1);
      @(negedge clk) sleep_n = 1'b0;
      @(negedge clk);
      check("R9 oe low in sleep", spi_miso_oe, 1'b0);
      @(negedge clk) sleep_n = 1'b1;
      @(negedge clk);
      check("R9 oe back after sleep", spi_miso_oe, 1'b1);
      cs_close();
      check("R9 oe low with cs high", spi_miso_oe, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_single_write();
      t_multi_write();
      t_read_all();
      t_read_live();
      t_out_of_range();
      t_last_wins();
      t_truncated();
      t_read_all();
      t_sleep();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule